// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Write-Back Cache

This block is a 1 KB direct-mapped data cache. It sits between a processor port that issues 32-bit byte addresses and a word-wide memory port. The cache has 32 lines of 32 bytes. Each line carries a single tag and a dirty flag. Each line is also cut into four 8-byte sub-blocks, and every sub-block has its own valid flag. A miss fetches only the sub-block that was touched, which takes two 32-bit memory beats, so a miss never loads a whole line.

Stores use write-back with allocation on a write miss. A write that misses first loads its sub-block and then merges its enabled bytes into the cache. Modified data reaches memory only when a different tag claims the line. At that point every valid sub-block of the victim is written out in ascending sub-block order, and then the line is retagged with all its sub-blocks invalid.

The processor holds `cpu_req_i` and its address, data and byte enables steady while `cpu_stall_o` is high. An access completes in the first cycle in which the request is present and the stall is low. In that cycle read data is valid and a write is committed at the following clock edge.

Top module: `sbc_cache`

## Requirements
- R1: After reset every sub-block is invalid, the stall is low when no request is present, and the first access to any address misses and fetches from memory.
- R2: Address bits [4:0] are the byte offset, [9:5] pick one of 32 lines, and [31:10] are the tag. Bits [4:3] pick the sub-block and bit [2] picks the word inside it. Accesses to a different line do not disturb a line.
- R3: A request whose tag matches and whose sub-block is valid completes with no stall and no memory traffic, and the addressed word appears on `cpu_rdata_o` in the same cycle.
- R4: A read miss fetches exactly the addressed sub-block with two read beats, at `{addr[31:3],3'b000}` and then `+4`.
- R5: Sub-blocks are tracked independently: after a fill, a different sub-block of the same line still misses.
- R6: A write hit stores `cpu_wdata_i` byte lane i (bits 8i+7:8i) only where `cpu_be_i[i]` is 1, causes no stall and produces no memory traffic.
- R7: A write miss first reads the addressed sub-block from memory (two beats, no memory writes) and then merges the enabled bytes.
- R8: When a dirty line is replaced, each of its valid sub-blocks is written to memory at the old tag address, two beats each, in ascending sub-block order. This happens before the fill, and memory then holds the modified bytes.
- R9: Replacing a clean line, or filling a sub-block under a matching tag, issues no memory write.
- R10: After a line is retagged, none of its previous sub-blocks hits. Another sub-block under the new tag misses, and the old tag misses.
- R11: `mem_req_o` stays high with stable address and direction, and with stable write data on writes, until `mem_ack_i`. Each acknowledged cycle completes one beat.
- R12: `cpu_stall_o` is high from the cycle a miss is seen until the access completes, and whenever memory traffic is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor access request, held while stalled |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_be_i | input | 4 | Byte enables for writes |
| cpu_rdata_o | output | 32 | Read data, valid when request is present and stall is low |
| cpu_stall_o | output | 1 | Access not yet complete |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, taken with acknowledge |
| mem_ack_i | input | 1 | Beat acknowledge |

## Verification
The hardest case to reach is the replacement of a dirty line whose valid sub-blocks are not contiguous. The victim must skip an invalid hole while writing back, and the bytes it writes must be the merged ones. The stimulus builds this up in steps. It fills two sub-blocks of one line, write-hits one of them with partial byte enables, and write-misses a third sub-block to leave a gap. It then reads the same index under a new tag. The memory transaction log is checked beat by beat, and the old addresses are re-read afterwards to show the merged data came back from memory.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EVICT, ST_FILL} sbc_state_e;
endpackage

// File: rtl/sbc_meta.sv
module sbc_meta #(
  parameter int LINES = 32,
  parameter int SUBS  = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES),
  localparam int SB_W  = $clog2(SUBS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             retag_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             set_valid_i,
  input  logic [SB_W-1:0]  set_sb_i,
  input  logic             set_dirty_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [SUBS-1:0]  valid_o,
  output logic             dirty_o
);
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [SUBS-1:0]  valid_q [LINES];
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]   <= '0;
        valid_q[i] <= '0;
      end
      dirty_q <= '0;
    end else begin
      if (retag_i) begin
        tag_q[idx_i]   <= tag_i;
        valid_q[idx_i] <= '0;
        dirty_q[idx_i] <= 1'b0;
      end
      if (set_valid_i) valid_q[idx_i][set_sb_i] <= 1'b1;
      if (set_dirty_i) dirty_q[idx_i] <= 1'b1;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
endmodule

// File: rtl/sbc_data.sv
module sbc_data #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 32,
  localparam int WA_W  = $clog2(WORDS),
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [WA_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NB-1:0]     be_i,
  input  logic [WA_W-1:0]   raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (be_i[b]) mem_q[waddr_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int SUBS  = 4,
  parameter int BEATS = 2,
  localparam int SB_W   = $clog2(SUBS),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              hit_i,
  input  logic              tag_match_i,
  input  logic              dirty_i,
  input  logic              live_i,
  input  logic              mem_ack_i,
  output logic              evict_o,
  output logic              fill_o,
  output logic [SB_W-1:0]   sb_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              retag_o,
  output logic              set_valid_o,
  output logic              fill_we_o,
  output logic              cpu_wr_o,
  output logic              stall_o
);
  sbc_state_e        state_q;
  logic [SB_W-1:0]   sb_q;
  logic [BEAT_W-1:0] beat_q;
  logic miss, last_beat, beat_done, sb_end;

  assign miss      = cpu_req_i && !hit_i;
  assign evict_o   = (state_q == ST_EVICT);
  assign fill_o    = (state_q == ST_FILL);
  assign mem_we_o  = evict_o && live_i;
  assign mem_req_o = mem_we_o || fill_o;
  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
  assign beat_done = mem_req_o && mem_ack_i;
  // victim sub-block finished: skipped as invalid or last beat acknowledged
  assign sb_end    = evict_o && (!live_i || (beat_done && last_beat));

  assign retag_o     = (state_q == ST_IDLE && miss && !tag_match_i && !dirty_i)
                    || (sb_end && sb_q == SB_W'(SUBS - 1));
  assign set_valid_o = fill_o && beat_done && last_beat;
  assign fill_we_o   = fill_o && beat_done;
  assign cpu_wr_o    = (state_q == ST_IDLE) && cpu_req_i && cpu_we_i && hit_i;
  assign stall_o     = (state_q != ST_IDLE) || miss;
  assign sb_o        = sb_q;
  assign beat_o      = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sb_q    <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss) begin
          beat_q  <= '0;
          sb_q    <= '0;
          state_q <= (!tag_match_i && dirty_i) ? ST_EVICT : ST_FILL;
        end
        ST_EVICT: begin
          if (sb_end) begin
            beat_q <= '0;
            if (sb_q == SB_W'(SUBS - 1)) state_q <= ST_FILL;
            else sb_q <= sb_q + 1'b1;
          end else if (beat_done) begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_FILL: if (beat_done) begin
          if (last_beat) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbc_cache.sv
module sbc_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 32,
  parameter int SUB_BYTES  = 8,
  localparam int NB      = DATA_W / 8,
  localparam int BO_W    = $clog2(NB),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int SUBS    = LINE_BYTES / SUB_BYTES,
  localparam int SB_W    = $clog2(SUBS),
  localparam int SBYTE_W = $clog2(SUB_BYTES),
  localparam int BEATS   = SUB_BYTES / NB,
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int WORDS   = LINES * LINE_BYTES / NB,
  localparam int WA_W    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [NB-1:0]     cpu_be_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [TAG_W-1:0]  a_tag, line_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [SB_W-1:0]   a_sb, sb;
  logic [BEAT_W-1:0] a_word, beat;
  logic [SUBS-1:0]   line_valid;
  logic line_dirty, tag_match, hit, live;
  logic evict, fill, retag, set_valid, fill_we, cpu_wr;
  logic [WA_W-1:0]   raddr, waddr;
  logic [DATA_W-1:0] rdata;
  logic unused_addr_bits;

  assign a_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign a_idx  = cpu_addr_i[OFF_W +: IDX_W];
  assign a_sb   = cpu_addr_i[SBYTE_W +: SB_W];
  assign a_word = cpu_addr_i[BO_W +: BEAT_W];
  assign unused_addr_bits = ^cpu_addr_i[BO_W-1:0];

  assign tag_match = (line_tag == a_tag);
  assign hit       = tag_match && line_valid[a_sb];
  assign live      = line_valid[sb];

  sbc_meta #(.LINES(LINES), .SUBS(SUBS), .TAG_W(TAG_W)) u_meta (
    .clk_i, .rst_ni,
    .idx_i(a_idx), .retag_i(retag), .tag_i(a_tag),
    .set_valid_i(set_valid), .set_sb_i(a_sb), .set_dirty_i(cpu_wr),
    .tag_o(line_tag), .valid_o(line_valid), .dirty_o(line_dirty)
  );

  sbc_ctrl #(.SUBS(SUBS), .BEATS(BEATS)) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .hit_i(hit), .tag_match_i(tag_match),
    .dirty_i(line_dirty), .live_i(live), .mem_ack_i,
    .evict_o(evict), .fill_o(fill), .sb_o(sb), .beat_o(beat),
    .mem_req_o, .mem_we_o, .retag_o(retag), .set_valid_o(set_valid),
    .fill_we_o(fill_we), .cpu_wr_o(cpu_wr), .stall_o(cpu_stall_o)
  );

  assign raddr = evict ? {a_idx, sb, beat} : {a_idx, a_sb, a_word};
  assign waddr = fill  ? {a_idx, a_sb, beat} : {a_idx, a_sb, a_word};

  sbc_data #(.WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i,
    .we_i(fill_we || cpu_wr), .waddr_i(waddr),
    .wdata_i(fill_we ? mem_rdata_i : cpu_wdata_i),
    .be_i(fill_we ? {NB{1'b1}} : cpu_be_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  assign mem_addr_o  = evict ? {line_tag, a_idx, sb, beat, {BO_W{1'b0}}}
                             : {a_tag, a_idx, a_sb, beat, {BO_W{1'b0}}};
  assign mem_wdata_o = rdata;
  assign cpu_rdata_o = rdata;
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 5,
  parameter int IDX_W   = 5,
  parameter int SBYTE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  localparam int TLO = OFF_W + IDX_W;

  // R11
  hs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R11
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ack_i |=> $stable(mem_wdata_o));

  // R12
  traffic_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cpu_stall_o);

  // R4
  fill_sb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && cpu_req_i
      |-> mem_addr_o[ADDR_W-1:SBYTE_W] == cpu_addr_i[ADDR_W-1:SBYTE_W]);

  // R8
  victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && cpu_req_i
      |-> mem_addr_o[TLO-1:OFF_W] == cpu_addr_i[TLO-1:OFF_W]
       && mem_addr_o[ADDR_W-1:TLO] != cpu_addr_i[ADDR_W-1:TLO]);
endmodule

bind sbc_cache sbc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .SBYTE_W(SBYTE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i),
  .cpu_stall_o(cpu_stall_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/sim_sbc_cache.sv
`timescale 1ns/1ps
module sim_sbc_cache;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic        cpu_stall, mem_req, mem_we;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int hs_viol = 0, stall_viol = 0;
  logic [31:0] mem_q [1024];
  logic [31:0] log_addr [64];
  logic        log_we [64];
  int          n_log = 0;

  always #4 clk = ~clk;

  sbc_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be), .cpu_rdata_o(cpu_rdata),
    .cpu_stall_o(cpu_stall), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'(i) * 32'h0101_0007 + 32'h1357_9BDF;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // memory responder: one wait cycle, then a one-cycle acknowledge
  initial begin
    bit waiting = 0;
    logic [31:0] held = '0;
    for (int i = 0; i < 1024; i++) mem_q[i] = pat(i);
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (!cpu_stall) stall_viol++;
        if (!waiting) begin
          held = mem_addr; waiting = 1;
        end else begin
          if (mem_addr !== held) hs_viol++;
          if (n_log < 64) begin log_addr[n_log] = mem_addr; log_we[n_log] = mem_we; end
          n_log++;
          if (mem_we) mem_q[mem_addr[11:2]] = mem_wdata;
          else mem_rdata = mem_q[mem_addr[11:2]];
          mem_ack = 1'b1; waiting = 0;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output int st);
    @(negedge clk);
    n_log = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    st = 0;
    #1;
    while (cpu_stall && st < 2000) begin
      st++;
      @(negedge clk); #1;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic expect_log(input string r, input int k, input logic [31:0] a, input bit w);
    chk({r, " log addr"}, log_addr[k], a);
    chk({r, " log dir"}, 32'(log_we[k]), 32'(w));
  endtask

  logic [31:0] rd;
  int st;
  logic [31:0] m44, m5c;

  task automatic t_reset();
    #1;
    chk("R1 idle stall", 32'(cpu_stall), 0);
    chk("R1 idle mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_read_miss();
    access(0, 32'h48, '0, '0, rd, st);
    chk("R1 cold miss stalls", 32'(st > 0), 1);
    chk("R4 read beats", 32'(n_log), 2);
    expect_log("R4", 0, 32'h48, 0);
    expect_log("R4", 1, 32'h4C, 0);
    chk("R4 read data", rd, pat(18));
    chk("R12 stall covers beats", 32'(st >= 4), 1);
  endtask

  task automatic t_read_hit();
    access(0, 32'h4C, '0, '0, rd, st);
    chk("R3 hit no stall", 32'(st), 0);
    chk("R3 hit no traffic", 32'(n_log), 0);
    chk("R3 hit data", rd, pat(19));
  endtask

  task automatic t_sub_independent();
    access(0, 32'h40, '0, '0, rd, st);
    chk("R5 other sub-block misses", 32'(n_log), 2);
    expect_log("R5", 0, 32'h40, 0);
    chk("R5 data", rd, pat(16));
  endtask

  task automatic t_write_hit();
    access(1, 32'h44, 32'hDEAD_BEEF, 4'b0101, rd, st);
    chk("R6 write hit no stall", 32'(st), 0);
    chk("R6 write hit no traffic", 32'(n_log), 0);
    access(0, 32'h44, '0, '0, rd, st);
    chk("R6 merged bytes", rd, m44);
  endtask

  task automatic t_write_miss();
    access(1, 32'h5C, 32'h1234_5678, 4'b1100, rd, st);
    chk("R7 write miss stalls", 32'(st > 0), 1);
    chk("R7 fetch beats", 32'(n_log), 2);
    expect_log("R7", 0, 32'h58, 0);
    expect_log("R7", 1, 32'h5C, 0);
    access(0, 32'h5C, '0, '0, rd, st);
    chk("R7 merged after fill", rd, m5c);
    access(0, 32'h58, '0, '0, rd, st);
    chk("R7 neighbour word filled", rd, pat(22));
    chk("R7 neighbour hit", 32'(st), 0);
  endtask

  task automatic t_evict_dirty();
    access(0, 32'h448, '0, '0, rd, st);
    chk("R8 beat count", 32'(n_log), 8);
    expect_log("R8", 0, 32'h40, 1);
    expect_log("R8", 1, 32'h44, 1);
    expect_log("R8", 2, 32'h48, 1);
    expect_log("R8", 3, 32'h4C, 1);
    expect_log("R8", 4, 32'h58, 1);
    expect_log("R8", 5, 32'h5C, 1);
    expect_log("R8", 6, 32'h448, 0);
    expect_log("R8", 7, 32'h44C, 0);
    chk("R8 memory merged 0x44", mem_q[17], m44);
    chk("R8 memory merged 0x5C", mem_q[23], m5c);
    chk("R8 fill data", rd, pat(274));
  endtask

  task automatic t_clean_replace();
    access(0, 32'h440, '0, '0, rd, st);
    chk("R10 new tag other sub-block misses", 32'(n_log), 2);
    chk("R9 no write under matching tag", 32'(log_we[0] | log_we[1]), 0);
    chk("R10 data", rd, pat(272));
    access(0, 32'h060, '0, '0, rd, st);
    chk("R2 other line fills", 32'(n_log), 2);
    expect_log("R2", 0, 32'h60, 0);
    access(0, 32'h444, '0, '0, rd, st);
    chk("R2 line undisturbed", 32'(st), 0);
    chk("R2 data", rd, pat(273));
    access(0, 32'h48, '0, '0, rd, st);
    chk("R10 old tag misses", 32'(n_log), 2);
    chk("R9 clean replace no write", 32'(log_we[0] | log_we[1]), 0);
    chk("R10 old data", rd, pat(18));
    access(0, 32'h44, '0, '0, rd, st);
    chk("R8 written-back data returns", rd, m44);
  endtask

  task automatic t_final();
    chk("R11 handshake held", 32'(hs_viol), 0);
    chk("R12 traffic only while stalled", 32'(stall_viol), 0);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m44 = (pat(17) & 32'hFF00_FF00) | (32'hDEAD_BEEF & 32'h00FF_00FF);
    m5c = {16'h1234, pat(23)[15:0]};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_sub_independent();
    t_write_hit();
    t_write_miss();
    t_evict_dirty();
    t_clean_replace();
    t_final();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule